// File: doc/BRIEF.md
# Extrinsic Leave-One-Out Node Processor

This block is the arithmetic core of one graph node in a fully parallel iterative decoder. It takes `D` signed messages in a single beat and returns `D` messages one clock later. Output lane `j` is the combination of every input lane except lane `j`. It is therefore the extrinsic value for the edge that carried input `j`, and the message sent back along an edge never contains what arrived on that same edge.

The combining operator is fixed at elaboration. The summing role adds messages exactly and saturates only when forming the output, which suits a variable node. The sign-minimum role takes the XOR of the signs and the smallest magnitude, which suits a parity node. A second parameter picks the internal structure. The prefix/suffix structure works for either operator. The total-then-remove structure subtracts each lane from one global sum and is only legal for the summing role. If it is requested for the sign-minimum role, the prefix/suffix structure is built instead.

Lane `j` of each message bus occupies bits `[j*W +: W]` in two's complement. Message storage, scheduling and iteration control sit outside this block.

Top module: `lonp_node_proc`

## Requirements
- R1: An input beat sampled with `in_valid` high at a rising clock edge appears on `out_msg` with `out_valid` high after that same edge. The latency is exactly one cycle, and input lane `j` never contributes to output lane `j`.
- R2: After an edge that samples `in_valid` low, `out_valid` is 0 and `out_msg` keeps its previous value whatever `in_msg` carries.
- R3: While `rst_n` is low, `out_valid` is 0 and `out_msg` is all zeros. Reset acts asynchronously.
- R4: In the summing role (`OP = OP_SUM`), output lane `j` equals the exact sum of all other lanes, clamped to the range `-2^(W-1)` to `2^(W-1)-1`.
- R5: In the sign-minimum role (`OP = OP_SIGNMIN`), a lane is negative when its top bit is 1. The output sign is the XOR of the other lanes' signs. The output magnitude is the smallest absolute value among the other lanes, where `-2^(W-1)` counts as magnitude `2^(W-1)`. A positive result of `2^(W-1)` is clamped to `2^(W-1)-1`.
- R6: In the summing role, the prefix/suffix structure (`ARCH = ARCH_FWDBWD`) and the total-then-remove structure (`ARCH = ARCH_TOTAL`) give bit-identical outputs for every input, saturated or not.
- R7: In the sign-minimum role, requesting `ARCH_TOTAL` builds the prefix/suffix structure, and the outputs follow R5.
- R8: With `D = 2`, output lane 0 equals input lane 1 and output lane 1 equals input lane 0, for either role.
- R9: Lane `j` of `in_msg` and `out_msg` occupies bits `[j*W +: W]`, and lane order is preserved from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat is valid |
| in_msg | input | D*W | D signed input messages, lane j at [j*W +: W] |
| out_valid | output | 1 | Output beat is valid, one cycle after in_valid |
| out_msg | output | D*W | D extrinsic output messages, lane j at [j*W +: W] |

## Verification
A broken prefix or suffix link corrupts every output lane whose exclusion window spans that link. The fault shows one cycle after the input beat, and only on vectors where the missing term differs from the identity. That is why the stimulus mixes signs, zeros and the most negative value. In the summing role, each internal extrinsic value plus its own lane must equal the same total on every beat, so a wrong chain element breaks that balance in the same cycle. A fault in the valid register or the hold enable shows as an output that changes on an idle beat, or as a valid flag that is out of step with the input by one cycle.

// File: rtl/lonp_pkg.sv
package lonp_pkg;

  typedef enum logic {
    OP_SUM     = 1'b0,
    OP_SIGNMIN = 1'b1
  } op_e;

  typedef enum logic {
    ARCH_FWDBWD = 1'b0,
    ARCH_TOTAL  = 1'b1
  } arch_e;

  // Internal element width: exact sum of D lanes plus one spare bit.
  function automatic int elem_width(input int w, input int d);
    return w + $clog2(d) + 1;
  endfunction

endpackage

// File: rtl/lonp_op_cell.sv
module lonp_op_cell
  import lonp_pkg::*;
#(
  parameter op_e OP = OP_SUM,
  parameter int  W  = 8,
  parameter int  EW = 12
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y
);

  // Sign-minimum element: bit W holds the sign, bits W-1:0 hold the magnitude.
  function automatic logic [EW-1:0] combine(input logic [EW-1:0] x, input logic [EW-1:0] z);
    logic [EW-1:0] r;
    r = '0;
    if (OP == OP_SUM) begin
      r = x + z;
    end else begin
      r[W]     = x[W] ^ z[W];
      r[W-1:0] = (x[W-1:0] < z[W-1:0]) ? x[W-1:0] : z[W-1:0];
    end
    return r;
  endfunction

  assign y = combine(a, b);

endmodule

// File: rtl/lonp_fb_chain.sv
module lonp_fb_chain
  import lonp_pkg::*;
#(
  parameter op_e           OP    = OP_SUM,
  parameter int            W     = 8,
  parameter int            D     = 6,
  parameter int            EW    = 12,
  parameter logic [EW-1:0] IDENT = '0
) (
  input  logic [D-1:0][EW-1:0] elem,
  output logic [D-1:0][EW-1:0] excl
);

  // pre[j]: lanes 0..j-1 combined; suf[j]: lanes j+1..D-1 combined.
  logic [D-1:0][EW-1:0] pre;
  logic [D-1:0][EW-1:0] suf;

  assign pre[0]   = IDENT;
  assign suf[D-1] = IDENT;

  for (genvar i = 1; i < D; i++) begin : g_pre
    lonp_op_cell #(.OP(OP), .W(W), .EW(EW)) u_pre (
      .a(pre[i-1]), .b(elem[i-1]), .y(pre[i])
    );
  end

  for (genvar i = 0; i < D - 1; i++) begin : g_suf
    lonp_op_cell #(.OP(OP), .W(W), .EW(EW)) u_suf (
      .a(suf[i+1]), .b(elem[i+1]), .y(suf[i])
    );
  end

  for (genvar j = 0; j < D; j++) begin : g_join
    lonp_op_cell #(.OP(OP), .W(W), .EW(EW)) u_join (
      .a(pre[j]), .b(suf[j]), .y(excl[j])
    );
  end

endmodule

// File: rtl/lonp_total_remove.sv
module lonp_total_remove #(
  parameter int D  = 6,
  parameter int EW = 12
) (
  input  logic [D-1:0][EW-1:0] elem,
  output logic [D-1:0][EW-1:0] excl,
  output logic [EW-1:0]        total
);

  // Modular EW-bit arithmetic; EW holds the full D-lane sum without wrap.
  function automatic logic [EW-1:0] sum_all(input logic [D-1:0][EW-1:0] v);
    logic [EW-1:0] acc;
    acc = '0;
    for (int i = 0; i < D; i++) acc = acc + v[i];
    return acc;
  endfunction

  assign total = sum_all(elem);

  for (genvar j = 0; j < D; j++) begin : g_remove
    assign excl[j] = total - elem[j];
  end

endmodule

// File: rtl/lonp_out_stage.sv
module lonp_out_stage
  import lonp_pkg::*;
#(
  parameter op_e OP = OP_SUM,
  parameter int  W  = 8,
  parameter int  D  = 6,
  parameter int  EW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [D-1:0][EW-1:0] excl,
  output logic                 out_valid,
  output logic [D*W-1:0]       out_msg
);

  localparam logic signed [EW-1:0] HI = EW'((1 <<< (W - 1)) - 1);
  localparam logic signed [EW-1:0] LO = EW'(-(1 <<< (W - 1)));

  function automatic logic [W-1:0] clamp(input logic signed [EW-1:0] v);
    if (v > HI) return HI[W-1:0];
    if (v < LO) return LO[W-1:0];
    return v[W-1:0];
  endfunction

  function automatic logic [W-1:0] to_msg(input logic [EW-1:0] e);
    logic signed [EW-1:0] v;
    logic signed [EW-1:0] m;
    if (OP == OP_SUM) begin
      v = e;
    end else begin
      m = '0;
      m[W-1:0] = e[W-1:0];
      v = e[W] ? -m : m;
    end
    return clamp(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int j = 0; j < D; j++) out_msg[j*W +: W] <= to_msg(excl[j]);
      end
    end
  end

endmodule

// File: rtl/lonp_node_proc.sv
module lonp_node_proc
  import lonp_pkg::*;
#(
  parameter int    D    = 6,
  parameter int    W    = 8,
  parameter op_e   OP   = OP_SUM,
  parameter arch_e ARCH = ARCH_FWDBWD
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [D*W-1:0] in_msg,
  output logic           out_valid,
  output logic [D*W-1:0] out_msg
);

  localparam int EW = elem_width(W, D);
  // Total-then-remove needs an inverse: only the summing role has one.
  localparam bit USE_TOTAL = (ARCH == ARCH_TOTAL) && (OP == OP_SUM);
  localparam logic [EW-1:0] IDENT =
    (OP == OP_SUM) ? '0 : (EW'(1) << (W - 1));

  // Named internal wires, visible to the bound checker.
  logic [D-1:0][EW-1:0] elem_w;
  logic [D-1:0][EW-1:0] excl_w;

  function automatic logic [EW-1:0] to_elem(input logic [W-1:0] x);
    logic [EW-1:0] r;
    r = '0;
    if (OP == OP_SUM) begin
      r = {{(EW - W){x[W-1]}}, x};
    end else begin
      r[W]     = x[W-1];
      r[W-1:0] = x[W-1] ? (~x + 1'b1) : x;
    end
    return r;
  endfunction

  for (genvar j = 0; j < D; j++) begin : g_lane
    assign elem_w[j] = to_elem(in_msg[j*W +: W]);
  end

  if (USE_TOTAL) begin : g_total
    logic [EW-1:0] total_w;
    lonp_total_remove #(.D(D), .EW(EW)) u_total (
      .elem(elem_w), .excl(excl_w), .total(total_w)
    );
  end else begin : g_fwdbwd
    lonp_fb_chain #(.OP(OP), .W(W), .D(D), .EW(EW), .IDENT(IDENT)) u_chain (
      .elem(elem_w), .excl(excl_w)
    );
  end

  lonp_out_stage #(.OP(OP), .W(W), .D(D), .EW(EW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .excl(excl_w),
    .out_valid(out_valid), .out_msg(out_msg)
  );

endmodule

// File: rtl/lonp_node_checker.sv
module lonp_node_checker
  import lonp_pkg::*;
#(
  parameter op_e OP = OP_SUM,
  parameter int  W  = 8,
  parameter int  D  = 6,
  parameter int  EW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [D*W-1:0]       in_msg,
  input logic                 out_valid,
  input logic [D*W-1:0]       out_msg,
  input logic [D-1:0][EW-1:0] elem,
  input logic [D-1:0][EW-1:0] excl
);

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_msg));

  if (OP == OP_SUM) begin : g_sum_chk
    for (genvar j = 1; j < D; j++) begin : g_lane
      // Each extrinsic value plus its own lane restores one common total (R4).
      assert_balance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (excl[j] + elem[j]) == (excl[0] + elem[0]));
    end
  end

  if (D == 2) begin : g_pair_chk
    assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_msg[0 +: W] == $past(in_msg[W +: W])) &&
                    (out_msg[W +: W] == $past(in_msg[0 +: W])));
  end

endmodule

bind lonp_node_proc lonp_node_checker #(.OP(OP), .W(W), .D(D), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
  .out_valid(out_valid), .out_msg(out_msg), .elem(elem_w), .excl(excl_w)
);

// File: tb/lonp_node_proc_test.sv
`timescale 1ns/1ps
module lonp_node_proc_test;
  import lonp_pkg::*;

  localparam int D  = 6;
  localparam int W  = 8;
  localparam int NV = 8;

  localparam int STIM [NV][D] = '{
    '{   1,    2,    3,    4,    5,    6},
    '{  -1,   -2,   -3,   -4,   -5,   -6},
    '{   0,    0,    0,    0,    0,    0},
    '{ 127,  127,  127,    0,    0,    0},
    '{-128, -128, -128, -128, -128, -128},
    '{  10,   -3,    7,  -20,    5,    1},
    '{ 100,  100,  -50,  -50,    0,    1},
    '{-128,    5,   -7,    3,   -1,    2}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [D*W-1:0] in_msg = '0;
  logic [2*W-1:0] in_d2 = '0;
  logic           ov_tot, ov_fb, ov_sm, ov_d2;
  logic [D*W-1:0] om_tot, om_fb, om_sm;
  logic [2*W-1:0] om_d2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lonp_node_proc #(.D(D), .W(W), .OP(OP_SUM), .ARCH(ARCH_TOTAL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(ov_tot), .out_msg(om_tot));
  lonp_node_proc #(.D(D), .W(W), .OP(OP_SUM), .ARCH(ARCH_FWDBWD)) uut_fb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(ov_fb), .out_msg(om_fb));
  lonp_node_proc #(.D(D), .W(W), .OP(OP_SIGNMIN), .ARCH(ARCH_TOTAL)) uut_sm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(ov_sm), .out_msg(om_sm));
  lonp_node_proc #(.D(2), .W(W), .OP(OP_SUM), .ARCH(ARCH_FWDBWD)) uut_d2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_d2),
    .out_valid(ov_d2), .out_msg(om_d2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int ref_sum(input int k, input int j);
    int s = 0;
    for (int i = 0; i < D; i++) if (i != j) s += STIM[k][i];
    return sat(s);
  endfunction

  function automatic int ref_sm(input int k, input int j);
    int neg = 0;
    int m = 128;
    for (int i = 0; i < D; i++) begin
      if (i != j) begin
        int a = (STIM[k][i] < 0) ? -STIM[k][i] : STIM[k][i];
        neg ^= (STIM[k][i] < 0) ? 1 : 0;
        if (a < m) m = a;
      end
    end
    return sat(neg != 0 ? -m : m);
  endfunction

  function automatic int lane(input logic [D*W-1:0] bus, input int j);
    return int'($signed(bus[j*W +: W]));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [D*W-1:0] held;
    // R3: reset state
    repeat (3) @(negedge clk);
    check(ov_tot == 1'b0, "R3 out_valid in reset", int'(ov_tot), 0);
    check(om_tot == '0, "R3 out_msg in reset", lane(om_tot, 0), 0);
    check(ov_sm == 1'b0, "R3 out_valid in reset (sign-min)", int'(ov_sm), 0);
    rst_n = 1'b1;

    // Vector table walk: R1, R4, R5, R6, R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int j = 0; j < D; j++) in_msg[j*W +: W] = W'(STIM[k][j]);
      @(negedge clk);
      in_valid = 1'b0;
      check(ov_tot && ov_fb && ov_sm, "R1 out_valid one cycle after beat", int'(ov_tot), 1);
      for (int j = 0; j < D; j++) begin
        check(lane(om_tot, j) == ref_sum(k, j), "R4 total-remove sum lane",
              lane(om_tot, j), ref_sum(k, j));
        check(lane(om_fb, j) == ref_sum(k, j), "R4 forward-backward sum lane",
              lane(om_fb, j), ref_sum(k, j));
        check(om_fb[j*W +: W] == om_tot[j*W +: W], "R6 structures bit-identical",
              lane(om_fb, j), lane(om_tot, j));
        check(lane(om_sm, j) == ref_sm(k, j), "R5 R7 sign-min lane",
              lane(om_sm, j), ref_sm(k, j));
      end
      if (k == 0) begin
        // R9: lane placement, lane 0 excludes 1, lane 5 excludes 6
        check(lane(om_tot, 0) == 20, "R9 lane 0 position", lane(om_tot, 0), 20);
        check(lane(om_tot, 5) == 15, "R9 lane 5 position", lane(om_tot, 5), 15);
      end
    end

    // R2: idle beat with new data must not disturb outputs
    held = om_tot;
    @(negedge clk);
    in_valid = 1'b0;
    in_msg = {D{8'h55}};
    @(negedge clk);
    check(ov_tot == 1'b0, "R2 out_valid low after idle beat", int'(ov_tot), 0);
    check(om_tot == held, "R2 out_msg held on idle beat", lane(om_tot, 0), lane(held, 0));

    // R8: two-lane node swaps its inputs
    @(negedge clk);
    in_valid = 1'b1;
    in_d2 = {8'sd127, -8'sd128};
    @(negedge clk);
    check($signed(om_d2[0 +: W]) == 127, "R8 lane 0 takes lane 1",
          int'($signed(om_d2[0 +: W])), 127);
    check($signed(om_d2[W +: W]) == -128, "R8 lane 1 takes lane 0",
          int'($signed(om_d2[W +: W])), -128);
    in_d2 = {-8'sd9, 8'sd5};
    @(negedge clk);
    in_valid = 1'b0;
    check($signed(om_d2[0 +: W]) == -9, "R8 lane 0 takes lane 1 (pair 2)",
          int'($signed(om_d2[0 +: W])), -9);
    check($signed(om_d2[W +: W]) == 5, "R8 lane 1 takes lane 0 (pair 2)",
          int'($signed(om_d2[W +: W])), 5);

    // R3: asynchronous reset mid-run
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ov_tot == 1'b0, "R3 async reset clears out_valid", int'(ov_tot), 0);
    check(om_tot == '0, "R3 async reset clears out_msg", lane(om_tot, 0), 0);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule